// File: doc/BRIEF.md
# STS-12 Transport Overhead Regeneration Multiplexer

This block rebuilds the transport overhead of an outgoing STS-12 frame, one byte per enabled clock, on a parallel byte bus. Internal row and column counters place every overhead byte on a grid of 9 rows by 36 columns. For each grid position the block picks one source. The sources are a fixed framing pattern, the byte that an upstream pointer generator presents, a byte held in a protection-switch buffer, a byte from an elastic store, or zero.

A frame-start strobe aligns the grid. A byte-enable paces it, so the upstream logic can send bursts with idle cycles between them. Two per-frame decisions are captured internally. The protection-byte mode is captured on the frame-start strobe. The negative-stuff decision is captured on the first byte of the pointer row. A line alarm input, honoured only in pass-through mode, drives the line overhead rows to all ones. Each chosen byte leaves the block one clock after its enabled input cycle, together with a valid flag.

Top module: `sts12_oh_regen`

## Requirements
- R1: In grid row 1 (internal row 0), columns 1 to 12 always output 0xF6.
- R2: In grid row 1, columns 13 to 24 always output 0x28.
- R3: In grid row 4 (internal row 3), columns 1 to 24 output the value on `ptr_byte_i` in the same enabled cycle.
- R4: In grid row 4, columns 25 to 36 output `es_byte_i` when the captured stuff flag is 1 and 0x00 otherwise. The stuff flag is captured from `neg_stuff_i` on the enabled byte at row 4 column 1, and no other cycle changes it.
- R5: Grid row 5 column 13 outputs `k1_buf_i` and grid row 5 column 25 outputs `k2_buf_i` while pass-through mode is captured (1). In zero mode (0) both positions output 0x00.
- R6: The mode is captured from `kpass_i` only in a cycle with `frame_start_i` high. A change of `kpass_i` at any other time has no effect on the protection bytes until the next frame start.
- R7: While pass-through mode is captured and `ais_l_i` is high, every byte in grid rows 4 to 9 outputs 0xFF. In zero mode `ais_l_i` has no effect.
- R8: Every grid position not named in R1 to R5 outputs 0x00.
- R9: A byte chosen in a cycle with `byte_en_i` high appears on `oh_byte_o` one clock later, with `oh_valid_o` high. After a cycle with `byte_en_i` low, `oh_valid_o` is low. The grid position advances only on enabled cycles.
- R10: A cycle with `frame_start_i` high is itself position row 1 column 1. If `byte_en_i` is also high in that cycle, that byte is the first A1 byte and the next enabled byte is column 2. Otherwise the next enabled byte is row 1 column 1. Column 36 wraps to column 1 of the next row, and row 9 column 36 wraps to row 1 column 1.
- R11: After reset `oh_valid_o` is 0 and `oh_byte_o` is 0x00, the position is row 1 column 1, zero mode is captured and the stuff flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Frame alignment strobe; captures the protection-byte mode |
| byte_en_i | input | 1 | One overhead byte is produced in this cycle |
| ptr_byte_i | input | 8 | Pointer generator byte for H1/H2 positions |
| neg_stuff_i | input | 1 | Negative stuff taken this frame (captured at row 4 column 1) |
| es_byte_i | input | 8 | Elastic store byte for H3 positions |
| k1_buf_i | input | 8 | Buffered first protection byte |
| k2_buf_i | input | 8 | Buffered second protection byte |
| kpass_i | input | 1 | 1 = pass buffered protection bytes, 0 = force zero |
| ais_l_i | input | 1 | Line alarm indication |
| oh_byte_o | output | 8 | Regenerated overhead byte |
| oh_valid_o | output | 1 | `oh_byte_o` holds a new byte |

## Verification
Two events can fall in the same cycle: a frame-start strobe and an enabled byte while the counters sit mid-frame. The bench sends forty bytes of a frame, then raises both inputs together. It expects that byte to be A1 (0xF6) and the next byte to be the second A1 column. A second case raises the strobe without the enable and expects the next enabled byte to be the first A1. The mode capture can also coincide with a `kpass_i` change mid-frame. That case is judged by the protection bytes of the running frame staying at their old mode.

// File: rtl/ohr_pkg.sv
package ohr_pkg;

   // Source chosen for one overhead grid position.
   typedef enum logic [2:0] {
      SRC_ZERO = 3'd0,
      SRC_A1   = 3'd1,
      SRC_A2   = 3'd2,
      SRC_PTR  = 3'd3,
      SRC_H3   = 3'd4,
      SRC_K1   = 3'd5,
      SRC_K2   = 3'd6
   } ohr_src_e;

endpackage

// File: rtl/ohr_pos_counter.sv
// Row/column tracker for the overhead grid. The current-cycle position is
// forced to the origin while frame_start_i is high.
module ohr_pos_counter #(
   parameter int ROWS = 9,
   parameter int COLS = 36,
   localparam int RW = $clog2(ROWS),
   localparam int CW = $clog2(COLS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_start_i,
   input  logic          byte_en_i,
   output logic [RW-1:0] row_cur_o,
   output logic [CW-1:0] col_cur_o
);

   localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
   localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

   logic [RW-1:0] row_q;
   logic [CW-1:0] col_q;

   assign row_cur_o = frame_start_i ? '0 : row_q;
   assign col_cur_o = frame_start_i ? '0 : col_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q <= '0;
         col_q <= '0;
      end else if (byte_en_i) begin
         if (col_cur_o == COL_LAST) begin
            col_q <= '0;
            row_q <= (row_cur_o == ROW_LAST) ? '0 : row_cur_o + 1'b1;
         end else begin
            col_q <= col_cur_o + 1'b1;
            row_q <= row_cur_o;
         end
      end else if (frame_start_i) begin
         row_q <= '0;
         col_q <= '0;
      end
   end

endmodule

// File: rtl/ohr_src_decode.sv
// Maps a grid position to its byte source and flags the line overhead rows.
module ohr_src_decode
   import ohr_pkg::*;
#(
   parameter int ROWS      = 9,
   parameter int NCH       = 12,
   parameter int FRAME_ROW = 0,
   parameter int PTR_ROW   = 3,
   parameter int APS_ROW   = 4,
   parameter int LINE_ROW  = 3,
   localparam int COLS = 3 * NCH,
   localparam int RW   = $clog2(ROWS),
   localparam int CW   = $clog2(COLS)
) (
   input  logic [RW-1:0] row_i,
   input  logic [CW-1:0] col_i,
   output ohr_src_e      src_o,
   output logic          in_line_o
);

   localparam logic [RW-1:0] R_FRAME = RW'(FRAME_ROW);
   localparam logic [RW-1:0] R_PTR   = RW'(PTR_ROW);
   localparam logic [RW-1:0] R_APS   = RW'(APS_ROW);
   localparam logic [RW-1:0] R_LINE  = RW'(LINE_ROW);
   localparam logic [CW-1:0] C_BND1  = CW'(NCH);
   localparam logic [CW-1:0] C_BND2  = CW'(2 * NCH);

   always_comb begin
      src_o = SRC_ZERO;
      if (row_i == R_FRAME) begin
         if (col_i < C_BND1)      src_o = SRC_A1;
         else if (col_i < C_BND2) src_o = SRC_A2;
      end else if (row_i == R_PTR) begin
         if (col_i < C_BND2) src_o = SRC_PTR;
         else                src_o = SRC_H3;
      end else if (row_i == R_APS) begin
         if (col_i == C_BND1)      src_o = SRC_K1;
         else if (col_i == C_BND2) src_o = SRC_K2;
      end
   end

   assign in_line_o = (row_i >= R_LINE);

endmodule

// File: rtl/ohr_ctl_latch.sv
// Per-frame controls: protection mode captured at frame start, stuff flag
// captured on the first enabled byte of the pointer row.
module ohr_ctl_latch #(
   parameter int ROWS    = 9,
   parameter int COLS    = 36,
   parameter int PTR_ROW = 3,
   localparam int RW = $clog2(ROWS),
   localparam int CW = $clog2(COLS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_start_i,
   input  logic          byte_en_i,
   input  logic [RW-1:0] row_i,
   input  logic [CW-1:0] col_i,
   input  logic          kpass_i,
   input  logic          neg_stuff_i,
   output logic          kpass_q_o,
   output logic          stuff_q_o
);

   localparam logic [RW-1:0] R_PTR = RW'(PTR_ROW);

   logic stuff_take;
   assign stuff_take = byte_en_i && (row_i == R_PTR) && (col_i == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kpass_q_o <= 1'b0;
         stuff_q_o <= 1'b0;
      end else begin
         if (frame_start_i) kpass_q_o <= kpass_i;
         if (stuff_take)    stuff_q_o <= neg_stuff_i;
      end
   end

endmodule

// File: rtl/sts12_oh_regen.sv
module sts12_oh_regen
   import ohr_pkg::*;
#(
   parameter int           W         = 8,
   parameter int           NCH       = 12,
   parameter int           ROWS      = 9,
   parameter int           FRAME_ROW = 0,
   parameter int           PTR_ROW   = 3,
   parameter int           APS_ROW   = 4,
   parameter int           LINE_ROW  = 3,
   parameter logic [W-1:0] A1_PAT    = W'(8'hF6),
   parameter logic [W-1:0] A2_PAT    = W'(8'h28),
   parameter bit           OUT_REG   = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         frame_start_i,
   input  logic         byte_en_i,
   input  logic [W-1:0] ptr_byte_i,
   input  logic         neg_stuff_i,
   input  logic [W-1:0] es_byte_i,
   input  logic [W-1:0] k1_buf_i,
   input  logic [W-1:0] k2_buf_i,
   input  logic         kpass_i,
   input  logic         ais_l_i,
   output logic [W-1:0] oh_byte_o,
   output logic         oh_valid_o
);

   localparam int COLS = 3 * NCH;
   localparam int RW   = $clog2(ROWS);
   localparam int CW   = $clog2(COLS);

   // Elaboration-time parameter checks
   if (W < 8) begin : g_bad_w
      $error("W must be at least 8");
   end
   if (NCH < 1) begin : g_bad_nch
      $error("NCH must be positive");
   end
   if (FRAME_ROW >= ROWS || PTR_ROW >= ROWS || APS_ROW >= ROWS || LINE_ROW >= ROWS) begin : g_bad_row
      $error("row parameters must lie inside the grid");
   end
   if (FRAME_ROW == PTR_ROW || FRAME_ROW == APS_ROW || PTR_ROW == APS_ROW) begin : g_row_clash
      $error("framing, pointer and protection rows must differ");
   end

   logic [RW-1:0] row_cur;
   logic [CW-1:0] col_cur;
   ohr_src_e      src;
   logic          in_line;
   logic          kpass_q;
   logic          stuff_q;
   logic [W-1:0]  byte_nxt;

   ohr_pos_counter #(.ROWS(ROWS), .COLS(COLS)) u_pos (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_start_i (frame_start_i),
      .byte_en_i     (byte_en_i),
      .row_cur_o     (row_cur),
      .col_cur_o     (col_cur)
   );

   ohr_src_decode #(
      .ROWS(ROWS), .NCH(NCH), .FRAME_ROW(FRAME_ROW), .PTR_ROW(PTR_ROW),
      .APS_ROW(APS_ROW), .LINE_ROW(LINE_ROW)
   ) u_dec (
      .row_i     (row_cur),
      .col_i     (col_cur),
      .src_o     (src),
      .in_line_o (in_line)
   );

   ohr_ctl_latch #(.ROWS(ROWS), .COLS(COLS), .PTR_ROW(PTR_ROW)) u_ctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_start_i (frame_start_i),
      .byte_en_i     (byte_en_i),
      .row_i         (row_cur),
      .col_i         (col_cur),
      .kpass_i       (kpass_i),
      .neg_stuff_i   (neg_stuff_i),
      .kpass_q_o     (kpass_q),
      .stuff_q_o     (stuff_q)
   );

   always_comb begin
      unique case (src)
         SRC_A1:  byte_nxt = A1_PAT;
         SRC_A2:  byte_nxt = A2_PAT;
         SRC_PTR: byte_nxt = ptr_byte_i;
         SRC_H3:  byte_nxt = stuff_q ? es_byte_i : '0;
         SRC_K1:  byte_nxt = kpass_q ? k1_buf_i : '0;
         SRC_K2:  byte_nxt = kpass_q ? k2_buf_i : '0;
         default: byte_nxt = '0;
      endcase
      if (kpass_q && ais_l_i && in_line) byte_nxt = '1;
   end

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            oh_byte_o  <= '0;
            oh_valid_o <= 1'b0;
         end else begin
            oh_valid_o <= byte_en_i;
            if (byte_en_i) oh_byte_o <= byte_nxt;
         end
      end
   end else begin : g_out_comb
      assign oh_byte_o  = byte_en_i ? byte_nxt : '0;
      assign oh_valid_o = byte_en_i;
   end

endmodule

// File: rtl/ohr_regen_chk.sv
module ohr_regen_chk #(
   parameter int           W         = 8,
   parameter int           NCH       = 12,
   parameter int           ROWS      = 9,
   parameter int           FRAME_ROW = 0,
   parameter int           PTR_ROW   = 3,
   parameter int           APS_ROW   = 4,
   parameter int           LINE_ROW  = 3,
   parameter logic [W-1:0] A1_PAT    = W'(8'hF6),
   parameter logic [W-1:0] A2_PAT    = W'(8'h28),
   parameter bit           OUT_REG   = 1'b1,
   localparam int COLS = 3 * NCH,
   localparam int RW   = $clog2(ROWS),
   localparam int CW   = $clog2(COLS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          frame_start_i,
   input logic          byte_en_i,
   input logic [W-1:0]  ptr_byte_i,
   input logic          ais_l_i,
   input logic [W-1:0]  oh_byte_o,
   input logic          oh_valid_o,
   input logic [RW-1:0] row_cur,
   input logic [CW-1:0] col_cur,
   input logic          kpass_q,
   input logic          stuff_q
);

   logic ais_act;
   assign ais_act = kpass_q && ais_l_i;

   if (OUT_REG) begin : g_lat
      assert_a1_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (byte_en_i && int'(row_cur) == FRAME_ROW && int'(col_cur) < NCH)
         |=> (oh_byte_o == A1_PAT));

      assert_a2_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (byte_en_i && int'(row_cur) == FRAME_ROW && int'(col_cur) >= NCH && int'(col_cur) < 2*NCH)
         |=> (oh_byte_o == A2_PAT));

      assert_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (byte_en_i && !ais_act && int'(row_cur) == PTR_ROW && int'(col_cur) < 2*NCH)
         |=> (oh_byte_o == $past(ptr_byte_i)));

      assert_h3_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (byte_en_i && !ais_act && !stuff_q && int'(row_cur) == PTR_ROW && int'(col_cur) >= 2*NCH)
         |=> (oh_byte_o == '0));

      assert_k_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (byte_en_i && !kpass_q && int'(row_cur) == APS_ROW &&
          (int'(col_cur) == NCH || int'(col_cur) == 2*NCH))
         |=> (oh_byte_o == '0));

      assert_ais_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (byte_en_i && ais_act && int'(row_cur) >= LINE_ROW)
         |=> (oh_byte_o == '1));

      assert_valid_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
         byte_en_i |=> oh_valid_o);

      assert_valid_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !byte_en_i |=> !oh_valid_o);
   end

   assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start_i |=> $stable(kpass_q));

   assert_col_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_en_i && int'(col_cur) == COLS - 1) |=> (col_cur == '0));

   assert_home_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start_i && !byte_en_i) |=> (row_cur == '0 && col_cur == '0));

   assert_pos_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_en_i && !frame_start_i) |=> ($stable(row_cur) && $stable(col_cur)) || frame_start_i);

endmodule

bind sts12_oh_regen ohr_regen_chk #(
   .W(W), .NCH(NCH), .ROWS(ROWS), .FRAME_ROW(FRAME_ROW), .PTR_ROW(PTR_ROW),
   .APS_ROW(APS_ROW), .LINE_ROW(LINE_ROW), .A1_PAT(A1_PAT), .A2_PAT(A2_PAT),
   .OUT_REG(OUT_REG)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .frame_start_i (frame_start_i),
   .byte_en_i     (byte_en_i),
   .ptr_byte_i    (ptr_byte_i),
   .ais_l_i       (ais_l_i),
   .oh_byte_o     (oh_byte_o),
   .oh_valid_o    (oh_valid_o),
   .row_cur       (row_cur),
   .col_cur       (col_cur),
   .kpass_q       (kpass_q),
   .stuff_q       (stuff_q)
);

// File: tb/sim_sts12_oh_regen.sv
module sim_sts12_oh_regen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_start_i = 1'b0;
   logic       byte_en_i = 1'b0;
   logic [7:0] ptr_byte_i = '0;
   logic       neg_stuff_i = 1'b0;
   logic [7:0] es_byte_i = '0;
   logic [7:0] k1_buf_i = 8'h3C;
   logic [7:0] k2_buf_i = 8'hC3;
   logic       kpass_i = 1'b0;
   logic       ais_l_i = 1'b0;
   logic [7:0] oh_byte_o;
   logic       oh_valid_o;

   int checks = 0;
   int errors = 0;

   // bench-side position and captured controls
   int br = 0;
   int bc = 0;
   bit mkp = 1'b0;
   bit mst = 1'b0;

   always #2.5 clk = ~clk;

   sts12_oh_regen u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_start_i (frame_start_i),
      .byte_en_i     (byte_en_i),
      .ptr_byte_i    (ptr_byte_i),
      .neg_stuff_i   (neg_stuff_i),
      .es_byte_i     (es_byte_i),
      .k1_buf_i      (k1_buf_i),
      .k2_buf_i      (k2_buf_i),
      .kpass_i       (kpass_i),
      .ais_l_i       (ais_l_i),
      .oh_byte_o     (oh_byte_o),
      .oh_valid_o    (oh_valid_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (row %0d col %0d)", tag, act, exp, br + 1, bc + 1);
      end
   endtask

   // Expected byte for a grid position, written from the requirements.
   function automatic logic [7:0] model(input int r, input int c, input bit kp, input bit st,
                                        input bit ais, input logic [7:0] ptr, input logic [7:0] es,
                                        output string tag);
      if (kp && ais && r >= 3) begin tag = "R7"; return 8'hFF; end
      if (r == 0 && c < 12) begin tag = "R1"; return 8'hF6; end
      if (r == 0 && c < 24) begin tag = "R2"; return 8'h28; end
      if (r == 3 && c < 24) begin tag = "R3"; return ptr; end
      if (r == 3)           begin tag = "R4"; return st ? es : 8'h00; end
      if (r == 4 && c == 12) begin tag = "R5"; return kp ? k1_buf_i : 8'h00; end
      if (r == 4 && c == 24) begin tag = "R5"; return kp ? k2_buf_i : 8'h00; end
      tag = "R8";
      return 8'h00;
   endfunction

   // One clock of stimulus with its own check one clock later.
   task automatic step(input bit fs, input bit en, input bit kp, input bit ns_at,
                       input bit ns_else, input bit ais, input string note);
      logic [7:0] exp;
      string      tag;
      int         r0;
      int         c0;
      @(negedge clk);
      if (fs) begin br = 0; bc = 0; mkp = kp; end
      frame_start_i = fs;
      byte_en_i     = en;
      kpass_i       = kp;
      ais_l_i       = ais;
      neg_stuff_i   = (br == 3 && bc == 0) ? ns_at : ns_else;
      ptr_byte_i    = 8'(bc * 7 + br * 3 + 1);
      es_byte_i     = 8'h5A ^ 8'(bc);
      exp = 8'h00;
      tag = "R9";
      r0 = br;
      c0 = bc;
      if (en) begin
         if (br == 3 && bc == 0) mst = neg_stuff_i;
         exp = model(br, bc, mkp, mst, ais, ptr_byte_i, es_byte_i, tag);
         if (bc == 35) begin
            bc = 0;
            br = (br == 8) ? 0 : br + 1;
         end else begin
            bc = bc + 1;
         end
      end
      @(posedge clk);
      #1;
      check(oh_valid_o == en, {"R9 valid ", note}, int'(oh_valid_o), int'(en));
      if (en) begin
         if (oh_byte_o != exp)
            $display("  at grid row %0d col %0d", r0 + 1, c0 + 1);
         check(oh_byte_o == exp, {tag, " ", note}, int'(oh_byte_o), int'(exp));
      end
   endtask

   task automatic run_frame(input bit kp_start, input bit kp_rest, input bit ns_at,
                            input bit ns_else, input bit ais, input bit gaps, input string note);
      step(1'b1, 1'b1, kp_start, ns_at, ns_else, ais, note);
      for (int i = 1; i < 324; i++) begin
         if (gaps && (i % 11) == 0) step(1'b0, 1'b0, kp_rest, ns_at, ns_else, ais, note);
         step(1'b0, 1'b1, kp_rest, ns_at, ns_else, ais, note);
      end
   endtask

   // R11: reset state, then a first byte without any frame start
   task automatic t_reset();
      @(negedge clk);
      check(oh_valid_o == 1'b0, "R11 valid after reset", int'(oh_valid_o), 0);
      check(oh_byte_o == 8'h00, "R11 byte after reset", int'(oh_byte_o), 0);
      step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R11 first byte at origin");
      step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R11 second byte");
   endtask

   // R8/R4/R9: zero mode, stuff taken, idle gaps, line alarm ignored in zero mode (R7)
   task automatic t_zero_mode();
      run_frame(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R8 zero mode gaps, R7 ignored");
   endtask

   // R5/R4: pass-through, stuff decision 0 at capture while 1 elsewhere
   task automatic t_pass_mode();
      k1_buf_i = 8'h96;
      k2_buf_i = 8'h69;
      run_frame(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R5 pass, R4 no stuff");
   endtask

   // R6: mode changes away from frame start do not act until the next frame
   task automatic t_mode_switch();
      run_frame(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6 held zero");
      run_frame(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6 held pass");
   endtask

   // R7: line alarm in pass-through mode
   task automatic t_alarm();
      run_frame(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R7 alarm");
   endtask

   // R10: wrap from last position into a new frame without a strobe
   task automatic t_wrap();
      for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10 wrap");
   endtask

   // R10: strobe coinciding with an enabled byte mid-frame, and alone
   task automatic t_restart();
      run_frame(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 lead-in");
      for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10 pre");
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10 strobe with byte");
      for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10 after");
      step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R10 strobe alone");
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 idle");
      for (int i = 0; i < 330; i++) step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R10 R6 after lone strobe");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_zero_mode();
      t_pass_mode();
      t_mode_switch();
      t_alarm();
      t_wrap();
      t_restart();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R9 watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule